// File: doc/BRIEF.md
# Ping-pong DMA buffer sequencer

This block sequences the two buffer descriptors of a single DMA channel. Each descriptor holds a byte count. Software loads the counts through a small register write port. The block tracks how many descriptors hold work and which one is being drained. While the channel is enabled, each pulse on the transfer strobe counts the active descriptor down by one. A strobe input stands in for the real data path.

A buffer ends in one of two ways: its count runs out, or an external end-of-transfer input arrives. When a buffer ends and the other descriptor is loaded, the block hands over to it at once and flags that the finished descriptor is free for reloading. When no other descriptor is waiting, the channel goes idle and raises a done flag. The block reports the cause of each ending in sticky status flags, drives an optional terminal-count pulse to the external device, and combines the enabled flags into one interrupt line.

The register map on `wr_addr` is:
- 0: count of descriptor 0.
- 1: count of descriptor 1.
- 2: control register.
- 3: write-one-to-clear register for the status flags.

Top module: `pp_dma_seq`

## Requirements
- R1: After reset, all of the following hold: `st_state` is 0, `st_next_free` is 0, `st_remain` is 0, and all four flags, `tc_out` and `irq` are low.
- R2: `st_state` encodes the state as 0 (no descriptor loaded), 1 (one loaded) or 2 (both loaded).
  - A nonzero write to address 0 or 1 in state 0 loads that count, makes that descriptor active and moves to state 1.
  - A nonzero write to the non-active count in state 1 loads it and moves to state 2.
  - A count write to the active descriptor in state 1, and any count write in state 2, is ignored.
- R3: A count write whose data is zero is ignored in every state.
- R4: When control bit 0 (enable) is set and the state is not 0, each cycle with `xfer_stb` high decrements `st_remain` by one. With enable clear, the strobe has no effect.
- R5: A strobe while `st_remain` is 1 ends the buffer. In state 2 this does all of the following: moves to state 1, switches `st_active` to the other descriptor (whose count appears on `st_remain` in the next cycle), and sets `st_nfb`. The first descriptor loaded is drained first.
- R6: A buffer ending in state 1 moves to state 0 and sets `st_done`.
- R7: `eot_in` high in a cycle ends the buffer, in the same way as R5 and R6, and sets `st_eots`. This applies only when the enable bit, control bit 1 (external mode) and control bit 3 (end-of-transfer input enable) are all set and the state is not 0. Otherwise `eot_in` is ignored.
- R8: Every count expiry sets `st_tcs`. `tc_out` is a one-cycle pulse in the cycle after the final strobe, which is the cycle in which the count reads zero. The pulse appears only when control bits 1 and 2 (terminal-count output enable) were both set.
- R9: `st_next_free` equals the inverse of `st_active` in states 0 and 1, and equals `st_active` in state 2.
- R10: `irq` is high exactly when (`st_done` and control bit 4) or (`st_nfb` and control bit 5).
- R11: A write to address 3 clears the flags whose bits are one: bit 0 clears done, bit 1 clears nfb, bit 2 clears tcs and bit 3 clears eots. A flag being set in the same cycle stays set.
- R12: A buffer that ends in state 1 in the same cycle as a valid load of the other descriptor hands over instead of going idle. The state stays 1, the active descriptor switches to the new load, `st_nfb` is set and `st_done` is not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register address (0, 1 counts; 2 control; 3 clear) |
| wr_data | input | CNT_W | Register write data |
| xfer_stb | input | 1 | One completed transfer (stub) |
| eot_in | input | 1 | External end-of-transfer request |
| tc_out | output | 1 | Terminal-count pulse to the external device |
| irq | output | 1 | Combined interrupt |
| st_state | output | 2 | Buffer state (0, 1, 2) |
| st_active | output | 1 | Index of the active descriptor |
| st_next_free | output | 1 | Index of the descriptor software may write next |
| st_remain | output | CNT_W | Remaining count of the active descriptor |
| st_done | output | 1 | Channel ran out of buffers |
| st_nfb | output | 1 | A descriptor was freed by a handover |
| st_tcs | output | 1 | A buffer ended by count expiry |
| st_eots | output | 1 | A buffer ended by the end-of-transfer input |

## Verification
The bench targets several corner cases. Each is listed with the fault it would expose:
- A reload of the active descriptor in state 1: a design that accepts it would overwrite a running count.
- A zero-count load: a design that accepts it would leave a channel that never ends.
- A buffer end on the same edge as a load of the other descriptor: a design that gets this wrong would either drop the new load or report a false done.
- A clear of a flag on the same edge as its set: a design that gets this wrong would lose the flag.
- End-of-transfer and expiry with external mode switched off: a design that ignores the mode would end buffers early or pulse `tc_out` when it must stay quiet.

// File: rtl/pp_dma_pkg.sv
package pp_dma_pkg;

   localparam int unsigned NBUF = 2;

   typedef enum logic [1:0] {
      BS_EMPTY = 2'd0,
      BS_ONE   = 2'd1,
      BS_TWO   = 2'd2
   } bstate_t;

   localparam int unsigned REG_CNT0 = 0;
   localparam int unsigned REG_CNT1 = 1;
   localparam int unsigned REG_CTRL = 2;
   localparam int unsigned REG_CLR  = 3;

   localparam int unsigned CFG_W = 6;

   localparam int unsigned FL_DONE = 0;
   localparam int unsigned FL_NFB  = 1;
   localparam int unsigned FL_TCS  = 2;
   localparam int unsigned FL_EOTS = 3;
   localparam int unsigned NFLAG   = 4;

   typedef struct packed {
      logic nfb_ie;
      logic done_ie;
      logic eot_en;
      logic tc_oe;
      logic ext;
      logic en;
   } cfg_t;

endpackage

// File: rtl/pp_dma_cfg.sv
module pp_dma_cfg
   import pp_dma_pkg::*;
#(
   parameter int unsigned ADDR_W    = 2,
   parameter int unsigned EOT_SYNC  = 0
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [ADDR_W-1:0]     wr_addr,
   input  logic [CFG_W-1:0]      wr_low,
   input  logic                  eot_in,
   output cfg_t                  cfg,
   output logic [NFLAG-1:0]      clr,
   output logic                  eot_s
);

   logic ctrl_hit;
   logic clr_hit;

   assign ctrl_hit = wr_en && (wr_addr == ADDR_W'(REG_CTRL));
   assign clr_hit  = wr_en && (wr_addr == ADDR_W'(REG_CLR));
   assign clr      = clr_hit ? wr_low[NFLAG-1:0] : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg <= '0;
      end else if (ctrl_hit) begin
         cfg <= cfg_t'(wr_low);
      end
   end

   generate
      if (EOT_SYNC == 0) begin : g_eot_direct
         assign eot_s = eot_in;
      end else begin : g_eot_sync
         logic [EOT_SYNC-1:0] sync_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sync_q <= '0;
            else        sync_q <= {sync_q[EOT_SYNC-1:0] , eot_in} >> 0;
         end
         assign eot_s = sync_q[EOT_SYNC-1];
      end
   endgenerate

endmodule

// File: rtl/pp_dma_bufctl.sv
module pp_dma_bufctl
   import pp_dma_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NBUF-1:0]  cnt_wr,
   input  logic             fin,
   output bstate_t          state,
   output logic             active,
   output logic [NBUF-1:0]  accept,
   output logic             handover,
   output logic             finish
);

   bstate_t   nstate;
   logic      nact;
   logic [NBUF-1:0] other_mask;

   assign other_mask = active ? 2'b01 : 2'b10;

   always_comb begin
      accept   = '0;
      nstate   = state;
      nact     = active;
      handover = 1'b0;
      finish   = 1'b0;
      case (state)
         BS_EMPTY: begin
            accept = cnt_wr;
            if (|cnt_wr) begin
               nstate = BS_ONE;
               nact   = cnt_wr[1];
            end
         end
         BS_ONE: begin
            accept = cnt_wr & other_mask;
            if (fin) begin
               if (|accept) begin
                  nact     = ~active;
                  handover = 1'b1;
               end else begin
                  nstate = BS_EMPTY;
                  finish = 1'b1;
               end
            end else if (|accept) begin
               nstate = BS_TWO;
            end
         end
         default: begin
            if (fin) begin
               nstate   = BS_ONE;
               nact     = ~active;
               handover = 1'b1;
            end
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= BS_EMPTY;
         active <= 1'b1;
      end else begin
         state  <= nstate;
         active <= nact;
      end
   end

   // R2: a full pair never drops straight to empty
   a_r2_two_not_empty: assert property (@(posedge clk) disable iff (!rst_n)
      (state == BS_TWO) |=> (state != BS_EMPTY));

   // R5: handover from two loaded buffers swaps the active index
   a_r5_handover_swap: assert property (@(posedge clk) disable iff (!rst_n)
      (state == BS_TWO && fin) |=> (state == BS_ONE && active != $past(active)));

   // R6: last buffer ending without a new load empties the channel
   a_r6_go_empty: assert property (@(posedge clk) disable iff (!rst_n)
      (state == BS_ONE && fin && cnt_wr == 2'b00) |=> (state == BS_EMPTY));

endmodule

// File: rtl/pp_dma_desc.sv
module pp_dma_desc
   import pp_dma_pkg::*;
#(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NBUF-1:0]  accept,
   input  logic [CNT_W-1:0] wr_data,
   input  logic             active,
   input  logic             dec,
   input  logic             fin,
   output logic [CNT_W-1:0] remain
);

   logic [CNT_W-1:0] cnt [NBUF];

   generate
      for (genvar i = 0; i < NBUF; i++) begin : g_desc
         logic is_act;
         assign is_act = (active == 1'(i));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt[i] <= '0;
            end else if (accept[i]) begin
               cnt[i] <= wr_data;
            end else if (fin && is_act) begin
               cnt[i] <= '0;
            end else if (dec && is_act) begin
               cnt[i] <= cnt[i] - CNT_W'(1);
            end
         end
      end
   endgenerate

   assign remain = cnt[active];

endmodule

// File: rtl/pp_dma_flags.sv
module pp_dma_flags
   import pp_dma_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NFLAG-1:0] set,
   input  logic [NFLAG-1:0] clr,
   input  logic             done_ie,
   input  logic             nfb_ie,
   output logic [NFLAG-1:0] flags,
   output logic             irq
);

   generate
      for (genvar i = 0; i < NFLAG; i++) begin : g_flag
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) flags[i] <= 1'b0;
            else        flags[i] <= set[i] | (flags[i] & ~clr[i]);
         end

         // R11: a clear with no coincident set drops the flag
         a_r11_clear: assert property (@(posedge clk) disable iff (!rst_n)
            (clr[i] && !set[i]) |=> !flags[i]);
      end
   endgenerate

   assign irq = (flags[FL_DONE] & done_ie) | (flags[FL_NFB] & nfb_ie);

   // R6: finishing the last buffer raises done in the next cycle
   a_r6_done_set: assert property (@(posedge clk) disable iff (!rst_n)
      set[FL_DONE] |=> flags[FL_DONE]);

endmodule

// File: rtl/pp_dma_seq.sv
module pp_dma_seq
   import pp_dma_pkg::*;
#(
   parameter int unsigned CNT_W    = 16,
   parameter int unsigned ADDR_W   = 2,
   parameter int unsigned EOT_SYNC = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [CNT_W-1:0]  wr_data,
   input  logic              xfer_stb,
   input  logic              eot_in,
   output logic              tc_out,
   output logic              irq,
   output logic [1:0]        st_state,
   output logic              st_active,
   output logic              st_next_free,
   output logic [CNT_W-1:0]  st_remain,
   output logic              st_done,
   output logic              st_nfb,
   output logic              st_tcs,
   output logic              st_eots
);

   generate
      if (CNT_W < CFG_W) begin : g_bad_cnt_w
         $error("CNT_W must cover the control register width");
      end
      if (ADDR_W < 2) begin : g_bad_addr_w
         $error("ADDR_W must address four registers");
      end
      if (EOT_SYNC > 3) begin : g_bad_sync
         $error("EOT_SYNC must be 0 to 3");
      end
   endgenerate

   cfg_t              cfg;
   logic [NFLAG-1:0]  clr;
   logic [NFLAG-1:0]  set;
   logic [NFLAG-1:0]  flags;
   logic              eot_s;
   logic [NBUF-1:0]   cnt_wr;
   logic [NBUF-1:0]   accept;
   bstate_t           state;
   logic              active;
   logic              handover;
   logic              finish;
   logic              run;
   logic              dec;
   logic              tc_end;
   logic              eot_end;
   logic              fin;
   logic              nonzero;
   logic              tc_q;

   assign nonzero = |wr_data;

   generate
      for (genvar i = 0; i < NBUF; i++) begin : g_cnt_wr
         assign cnt_wr[i] = wr_en && nonzero && (wr_addr == ADDR_W'(i));
      end
   endgenerate

   pp_dma_cfg #(.ADDR_W(ADDR_W), .EOT_SYNC(EOT_SYNC)) cfg_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_low  (wr_data[CFG_W-1:0]),
      .eot_in  (eot_in),
      .cfg     (cfg),
      .clr     (clr),
      .eot_s   (eot_s)
   );

   assign run     = cfg.en && (state != BS_EMPTY);
   assign dec     = run && xfer_stb;
   assign tc_end  = dec && (st_remain == CNT_W'(1));
   assign eot_end = run && cfg.ext && cfg.eot_en && eot_s;
   assign fin     = tc_end || eot_end;

   pp_dma_bufctl ctl_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .cnt_wr   (cnt_wr),
      .fin      (fin),
      .state    (state),
      .active   (active),
      .accept   (accept),
      .handover (handover),
      .finish   (finish)
   );

   pp_dma_desc #(.CNT_W(CNT_W)) desc_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .accept  (accept),
      .wr_data (wr_data),
      .active  (active),
      .dec     (dec),
      .fin     (fin),
      .remain  (st_remain)
   );

   always_comb begin
      set          = '0;
      set[FL_DONE] = finish;
      set[FL_NFB]  = handover;
      set[FL_TCS]  = tc_end;
      set[FL_EOTS] = eot_end;
   end

   pp_dma_flags flags_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .set     (set),
      .clr     (clr),
      .done_ie (cfg.done_ie),
      .nfb_ie  (cfg.nfb_ie),
      .flags   (flags),
      .irq     (irq)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tc_q <= 1'b0;
      else        tc_q <= tc_end && cfg.ext && cfg.tc_oe;
   end

   assign tc_out       = tc_q;
   assign st_state     = state;
   assign st_active    = active;
   assign st_next_free = (state == BS_TWO) ? active : ~active;
   assign st_done      = flags[FL_DONE];
   assign st_nfb       = flags[FL_NFB];
   assign st_tcs       = flags[FL_TCS];
   assign st_eots      = flags[FL_EOTS];

   // R3: a zero count written while empty leaves the channel empty
   a_r3_zero_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (state == BS_EMPTY && wr_en && wr_addr < ADDR_W'(REG_CLR - 1) && wr_data == '0)
      |=> (st_state == 2'd0));

   // R4: a strobe that does not end the buffer takes exactly one off
   a_r4_decrement: assert property (@(posedge clk) disable iff (!rst_n)
      (dec && !fin) |=> (st_remain == $past(st_remain) - CNT_W'(1)));

   // R8: the terminal-count pulse needs external mode and output enable
   a_r8_tc_gated: assert property (@(posedge clk) disable iff (!rst_n)
      tc_out |-> $past(cfg.ext && cfg.tc_oe && state != BS_EMPTY));

   // R8: the pulse lasts one cycle
   a_r8_tc_single: assert property (@(posedge clk) disable iff (!rst_n)
      tc_out |=> !tc_out);

endmodule

// File: tb/pp_dma_seq_tb.sv
`timescale 1ns/1ps
module pp_dma_seq_tb_top;

   localparam int CW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [1:0]    wr_addr = '0;
   logic [CW-1:0] wr_data = '0;
   logic          xfer_stb = 1'b0;
   logic          eot_in = 1'b0;
   logic          tc_out, irq, st_active, st_next_free;
   logic          st_done, st_nfb, st_tcs, st_eots;
   logic [1:0]    st_state;
   logic [CW-1:0] st_remain;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   pp_dma_seq #(.CNT_W(CW), .ADDR_W(2), .EOT_SYNC(0)) dut_i (
      .clk, .rst_n, .wr_en, .wr_addr, .wr_data, .xfer_stb, .eot_in,
      .tc_out, .irq, .st_state, .st_active, .st_next_free, .st_remain,
      .st_done, .st_nfb, .st_tcs, .st_eots
   );

   // behavioural reference
   int            m_state;
   bit            m_act;
   int            m_cnt [2];
   bit            m_done, m_nfb, m_tcs, m_eots, m_tc;
   bit [5:0]      m_ctrl;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_state = 0; m_act = 1; m_cnt[0] = 0; m_cnt[1] = 0;
         m_done = 0; m_nfb = 0; m_tcs = 0; m_eots = 0; m_tc = 0; m_ctrl = '0;
      end else begin
         bit run, tc_e, eot_e, fin, ld;
         int idx;
         run   = m_ctrl[0] && m_state != 0;
         tc_e  = run && xfer_stb && m_cnt[m_act] == 1;
         eot_e = run && m_ctrl[1] && m_ctrl[3] && eot_in;
         fin   = tc_e || eot_e;
         ld    = wr_en && wr_addr < 2 && wr_data != 0;
         idx   = int'(wr_addr[0]);
         m_tc  = tc_e && m_ctrl[1] && m_ctrl[2];
         if (wr_en && wr_addr == 3) begin
            if (wr_data[0]) m_done = 0;
            if (wr_data[1]) m_nfb = 0;
            if (wr_data[2]) m_tcs = 0;
            if (wr_data[3]) m_eots = 0;
         end
         if (tc_e) m_tcs = 1;
         if (eot_e) m_eots = 1;
         if (m_state == 0) begin
            if (ld) begin m_cnt[idx] = int'(wr_data); m_act = idx[0]; m_state = 1; end
         end else if (m_state == 1) begin
            if (fin) begin
               m_cnt[m_act] = 0;
               if (ld && idx != int'(m_act)) begin
                  m_cnt[idx] = int'(wr_data); m_act = idx[0]; m_nfb = 1;
               end else begin
                  m_state = 0; m_done = 1;
               end
            end else begin
               if (run && xfer_stb) m_cnt[m_act] = m_cnt[m_act] - 1;
               if (ld && idx != int'(m_act)) begin m_cnt[idx] = int'(wr_data); m_state = 2; end
            end
         end else begin
            if (fin) begin
               m_cnt[m_act] = 0; m_act = !m_act; m_state = 1; m_nfb = 1;
            end else if (run && xfer_stb) begin
               m_cnt[m_act] = m_cnt[m_act] - 1;
            end
         end
         if (wr_en && wr_addr == 2) m_ctrl = wr_data[5:0];
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   // every-cycle comparison against the reference
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         chk(int'(st_state) == m_state, "R2 state", int'(st_state), m_state);
         chk(st_active == m_act, "R5 active", int'(st_active), int'(m_act));
         chk(int'(st_remain) == m_cnt[m_act], "R4 remain", int'(st_remain), m_cnt[m_act]);
         chk(st_next_free == ((m_state == 2) ? m_act : !m_act), "R9 next_free",
             int'(st_next_free), int'((m_state == 2) ? m_act : !m_act));
         chk(st_done == m_done, "R6 done", int'(st_done), int'(m_done));
         chk(st_nfb == m_nfb, "R5 nfb", int'(st_nfb), int'(m_nfb));
         chk(st_tcs == m_tcs, "R8 tcs", int'(st_tcs), int'(m_tcs));
         chk(st_eots == m_eots, "R7 eots", int'(st_eots), int'(m_eots));
         chk(tc_out == m_tc, "R8 tc_out", int'(tc_out), int'(m_tc));
         chk(irq == ((m_done && m_ctrl[4]) || (m_nfb && m_ctrl[5])), "R10 irq",
             int'(irq), int'((m_done && m_ctrl[4]) || (m_nfb && m_ctrl[5])));
      end
   end

   task automatic drv(input bit we, input int a, input int d, input bit s, input bit e);
      @(negedge clk);
      wr_en = we; wr_addr = 2'(a); wr_data = CW'(d); xfer_stb = s; eot_in = e;
   endtask

   task automatic idle();
      drv(0, 0, 0, 0, 0);
   endtask

   task automatic stb();
      drv(0, 0, 0, 1, 0);
   endtask

   initial begin
      #200000;
      if (!finished) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=hung expected=done");
         finished = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      idle();
      // R1 reset state
      chk(st_state == 2'd0 && st_next_free == 0 && st_remain == 0, "R1 state", int'(st_state), 0);
      chk({st_done, st_nfb, st_tcs, st_eots, tc_out, irq} == 6'b0, "R1 flags",
          int'({st_done, st_nfb, st_tcs, st_eots, tc_out, irq}), 0);
      // R3 zero load ignored
      drv(1, 0, 0, 0, 0); idle();
      chk(st_state == 2'd0, "R3 zero load", int'(st_state), 0);
      // R2 first load, then reload of active ignored
      drv(1, 0, 3, 0, 0); idle();
      chk(st_state == 2'd1 && st_active == 0 && st_remain == 3, "R2 load0", int'(st_remain), 3);
      drv(1, 0, 9, 0, 0); idle();
      chk(st_remain == 3, "R2 active reload ignored", int'(st_remain), 3);
      // R4 strobe without enable
      stb(); idle();
      chk(st_remain == 3, "R4 disabled strobe", int'(st_remain), 3);
      drv(1, 1, 4, 0, 0); idle();
      chk(st_state == 2'd2 && st_next_free == 0, "R9 both loaded", int'(st_state), 2);
      drv(1, 1, 7, 0, 0); idle();
      chk(st_state == 2'd2 && st_remain == 3, "R2 write in two ignored", int'(st_remain), 3);
      drv(1, 2, 'h3F, 0, 0);
      stb(); stb(); stb(); idle();
      chk(tc_out && st_state == 2'd1 && st_active == 1 && st_remain == 4, "R5 handover",
          int'(st_remain), 4);
      chk(st_nfb && irq, "R10 nfb irq", int'(irq), 1);
      idle();
      chk(!tc_out, "R8 single pulse", int'(tc_out), 0);
      drv(1, 3, 2, 0, 0); idle();
      chk(!st_nfb && !irq && st_tcs, "R11 clear nfb", int'(st_nfb), 0);
      stb(); drv(0, 0, 0, 0, 1); idle();
      chk(st_state == 2'd0 && st_done && st_eots && irq && !tc_out, "R7 eot end",
          int'(st_state), 0);
      chk(st_done, "R6 done", int'(st_done), 1);
      drv(1, 3, 'hF, 0, 0);
      // R12 end and load of the other descriptor on one edge
      drv(1, 0, 2, 0, 0); idle();
      stb(); drv(1, 1, 6, 1, 0); idle();
      chk(st_state == 2'd1 && st_active == 1 && st_remain == 6 && st_nfb && !st_done,
          "R12 merged handover", int'(st_remain), 6);
      drv(1, 3, 'hF, 0, 0);
      for (int k = 0; k < 5; k++) stb();
      drv(1, 3, 4, 1, 0); idle();
      chk(st_tcs, "R11 set wins over clear", int'(st_tcs), 1);
      chk(st_state == 2'd0 && st_done, "R6 last buffer done", int'(st_state), 0);
      drv(1, 3, 'hF, 0, 0);
      drv(1, 2, 'h31, 0, 0);
      drv(1, 1, 2, 0, 0);
      drv(0, 0, 0, 0, 1); idle();
      chk(st_state == 2'd1 && st_remain == 2 && !st_eots, "R7 eot ignored", int'(st_remain), 2);
      stb(); stb(); idle();
      chk(!tc_out && st_tcs && st_state == 2'd0, "R8 no pulse without ext", int'(tc_out), 0);
      repeat (3) idle();
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule